// File: doc/BRIEF.md
# ADC Auto-Trigger Source Selector

This block decides in which clock cycle an analog-to-digital conversion is started. A 3-bit select code chooses one of eight trigger signals: seven come from outside the block (comparator, external interrupt, timer events), and code 000 is free-running mode. In free-running mode the conversion-complete flag acts as the trigger, so each finished conversion starts the next one. Edge detection sits after the multiplexer. A change of the select code can therefore create a trigger edge by itself. A switch into free-running mode is kept from doing so.

A start is a single-cycle pulse, registered one clock after the rising edge is seen. It is raised only while the converter and auto-trigger enables are both set and the converter is not busy. A trigger edge that arrives during a busy period is dropped and is not queued. Free-running mode is not allowed on differential channels. Asking for it while the differential flag is set raises an error flag and blocks all starts.

The block also holds a 16-bit mask that disables digital inputs. Each set bit forces the digital read value of its analog pin to zero. The mask is loaded as a whole word through a write strobe.

Top module: `adc_trig_sel`

## Requirements
- R1: Select code to trigger source: 000 = conversion-complete flag (free running); 001..111 = `trig_in[code-1]`, i.e. 001 comparator, 010 external interrupt 0, 011 timer 0 compare A, 100 timer 0 overflow, 101 timer 1 compare B, 110 timer 1 overflow, 111 timer 1 capture. Edges on sources that are not selected start nothing.
- R2: `start_pulse` is high in the cycle after the selected signal goes from 0 to 1, and only if both `conv_en` and `auto_en` were 1 in the cycle of the edge.
- R3: Changing the select code from a source that is low to a source that is high starts a conversion.
- R4: Changing the select code to 000 never starts a conversion, even if the conversion-complete flag is already high.
- R5: In free-running mode, a rising edge of `conv_done` starts a conversion.
- R6: While the select code is 000 and `diff_ch` is 1, `cfg_err` is high in the following cycle and no start is issued.
- R7: A trigger edge seen while `conv_busy` is 1 is ignored and is not issued after busy falls.
- R8: `start_pulse` never stays high for two cycles in a row.
- R9: `pin_rd[i]` is `pin_raw[i]` AND NOT mask bit i. The mask is loaded from `msk_wdata` on a clock edge with `msk_we` = 1, and it resets to all zeros.
- R10: The stored previous value of the selected signal resets to 0. A source that is already high when reset is released, with both enables set, starts a conversion in the first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_en | input | 1 | Converter enable |
| auto_en | input | 1 | Auto-trigger enable |
| diff_ch | input | 1 | Differential channel selected |
| src_sel | input | 3 | Trigger source select code |
| trig_in | input | 7 | External trigger sources for codes 001..111 |
| conv_done | input | 1 | Conversion-complete flag |
| conv_busy | input | 1 | Conversion in progress |
| msk_we | input | 1 | Load strobe for the digital-input disable mask |
| msk_wdata | input | 16 | New mask value |
| pin_raw | input | 16 | Raw digital pin levels |
| start_pulse | output | 1 | One-cycle conversion start |
| cfg_err | output | 1 | Free-running mode requested on a differential channel |
| pin_rd | output | 16 | Gated digital pin read values |

## Verification
The bench tests switching into free-running mode while the complete flag is high. A design that detects edges on the raw multiplexer output would fire a start there. It also tests switching from a low source to a high one, where a design that detects edges per source before the multiplexer would stay silent. Edges during busy are followed by busy falling with the source still high; a design that queued the request would fire late. A source held high across reset release catches a previous-value register that resets to 1. The mask is checked through the gated pin values, both after reset and after a load.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

  typedef enum logic [2:0] {
    SRC_FREE_RUN  = 3'd0,
    SRC_ACOMP     = 3'd1,
    SRC_EXT_IRQ0  = 3'd2,
    SRC_TMR0_CMPA = 3'd3,
    SRC_TMR0_OVF  = 3'd4,
    SRC_TMR1_CMPB = 3'd5,
    SRC_TMR1_OVF  = 3'd6,
    SRC_TMR1_CAPT = 3'd7
  } trig_src_e;

endpackage

// File: rtl/adc_trig_mux.sv
module adc_trig_mux #(
  parameter int SEL_W = 3,
  localparam int NUM_CODES = 1 << SEL_W,
  localparam int NUM_EXT = NUM_CODES - 1
) (
  input  logic [SEL_W-1:0]   sel,
  input  logic               done,
  input  logic [NUM_EXT-1:0] ext,
  input  logic               diff,
  output logic               sel_val,
  output logic               fr_bad
);

  logic [NUM_CODES-1:0] all_src;
  logic                 is_free;

  assign all_src = {ext, done};
  assign is_free = (sel == '0);
  assign fr_bad  = is_free & diff;

  always_comb begin
    sel_val = 1'b0;
    for (int i = 0; i < NUM_CODES; i++) begin
      if (sel == SEL_W'(i)) sel_val = all_src[i];
    end
    if (fr_bad) sel_val = 1'b0;
  end

endmodule

// File: rtl/adc_trig_edge.sv
module adc_trig_edge #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic             sel_val,
  output logic             rise
);

  logic             prev_q;
  logic [SEL_W-1:0] sel_q;
  logic             into_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      sel_q  <= '0;
    end else begin
      prev_q <= sel_val;
      sel_q  <= sel;
    end
  end

  assign into_free = (sel == '0) && (sel_q != '0);
  assign rise      = sel_val & ~prev_q & ~into_free;

endmodule

// File: rtl/adc_din_gate.sv
module adc_din_gate #(
  parameter int NUM_PINS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [NUM_PINS-1:0] wdata,
  input  logic [NUM_PINS-1:0] raw,
  output logic [NUM_PINS-1:0] rd
);

  logic [NUM_PINS-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else if (we) mask_q <= wdata;
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    assign rd[g] = raw[g] & ~mask_q[g];
  end

endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel #(
  parameter int NUM_PINS = 16,
  parameter int SEL_W = 3,
  localparam int NUM_EXT = (1 << SEL_W) - 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                conv_en,
  input  logic                auto_en,
  input  logic                diff_ch,
  input  logic [SEL_W-1:0]    src_sel,
  input  logic [NUM_EXT-1:0]  trig_in,
  input  logic                conv_done,
  input  logic                conv_busy,
  input  logic                msk_we,
  input  logic [NUM_PINS-1:0] msk_wdata,
  input  logic [NUM_PINS-1:0] pin_raw,
  output logic                start_pulse,
  output logic                cfg_err,
  output logic [NUM_PINS-1:0] pin_rd
);

  logic sel_val;
  logic fr_bad;
  logic rise;
  logic start_q;
  logic err_q;

  adc_trig_mux #(.SEL_W(SEL_W)) u_mux (
    .sel     (src_sel),
    .done    (conv_done),
    .ext     (trig_in),
    .diff    (diff_ch),
    .sel_val (sel_val),
    .fr_bad  (fr_bad)
  );

  adc_trig_edge #(.SEL_W(SEL_W)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (src_sel),
    .sel_val (sel_val),
    .rise    (rise)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      start_q <= rise & conv_en & auto_en & ~conv_busy & ~fr_bad;
      err_q   <= fr_bad;
    end
  end

  assign start_pulse = start_q;
  assign cfg_err     = err_q;

  adc_din_gate #(.NUM_PINS(NUM_PINS)) u_din (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (msk_we),
    .wdata (msk_wdata),
    .raw   (pin_raw),
    .rd    (pin_rd)
  );

endmodule

// File: rtl/adc_trig_sel_chk.sv
module adc_trig_sel_chk #(
  parameter int NUM_PINS = 16,
  parameter int SEL_W = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                conv_en,
  input logic                auto_en,
  input logic                diff_ch,
  input logic [SEL_W-1:0]    src_sel,
  input logic                conv_busy,
  input logic                start_pulse,
  input logic                cfg_err,
  input logic [NUM_PINS-1:0] pin_raw,
  input logic [NUM_PINS-1:0] pin_rd
);

  p_enables_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> $past(conv_en && auto_en));

  p_free_switch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && src_sel == '0 && $past(src_sel) != '0) |=> !start_pulse);

  p_diff_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (diff_ch && src_sel == '0) |=> (cfg_err && !start_pulse));

  p_busy_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> $past(!conv_busy));

  p_single_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);

  p_mask_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_rd & ~pin_raw) == '0);

endmodule

bind adc_trig_sel adc_trig_sel_chk #(.NUM_PINS(NUM_PINS), .SEL_W(SEL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .conv_en     (conv_en),
  .auto_en     (auto_en),
  .diff_ch     (diff_ch),
  .src_sel     (src_sel),
  .conv_busy   (conv_busy),
  .start_pulse (start_pulse),
  .cfg_err     (cfg_err),
  .pin_raw     (pin_raw),
  .pin_rd      (pin_rd)
);

// File: tb/test_adc_trig_sel.sv
`timescale 1ns/1ps
module test_adc_trig_sel;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_en = 1'b1, auto_en = 1'b1, diff_ch = 1'b0;
  logic [2:0]  src_sel = 3'd1;
  logic [6:0]  trig_in = 7'd0;
  logic        conv_done = 1'b0, conv_busy = 1'b0;
  logic        msk_we = 1'b0;
  logic [15:0] msk_wdata = 16'd0, pin_raw = 16'hFFFF;
  logic        start_pulse, cfg_err;
  logic [15:0] pin_rd;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  adc_trig_sel i_adc_trig_sel (
    .clk(clk), .rst_n(rst_n), .conv_en(conv_en), .auto_en(auto_en),
    .diff_ch(diff_ch), .src_sel(src_sel), .trig_in(trig_in),
    .conv_done(conv_done), .conv_busy(conv_busy), .msk_we(msk_we),
    .msk_wdata(msk_wdata), .pin_raw(pin_raw), .start_pulse(start_pulse),
    .cfg_err(cfg_err), .pin_rd(pin_rd)
  );

  // Selected trigger level as given by R1 (free running blocked under R6)
  function automatic logic exp_sel(input logic [2:0] s, input logic d,
                                   input logic [6:0] t, input logic df);
    if (s == 3'd0) return df ? 1'b0 : d;
    return t[s-1];
  endfunction

  logic        m_prev, m_start, m_err;
  logic [2:0]  m_selq;
  logic [15:0] m_mask;

  always @(posedge clk) begin
    logic v, bad;
    if (!rst_n) begin
      m_prev <= 1'b0; m_selq <= 3'd0; m_start <= 1'b0; m_err <= 1'b0; m_mask <= 16'd0;
    end else begin
      v   = exp_sel(src_sel, conv_done, trig_in, diff_ch);
      bad = (src_sel == 3'd0) && diff_ch;
      m_start <= v && !m_prev && !(src_sel == 3'd0 && m_selq != 3'd0) &&
                 conv_en && auto_en && !conv_busy && !bad;
      m_err  <= bad;
      m_prev <= v;
      m_selq <= src_sel;
      if (msk_we) m_mask <= msk_wdata;
    end
  end

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    // R10: source 001 high through reset, enables set
    trig_in = 7'b0000001;
    tick(); tick();
    chk(start_pulse, 0, "R2 reset start");
    chk(cfg_err, 0, "R6 reset err");
    chk(pin_rd, 16'hFFFF, "R9 reset mask");
    rst_n = 1'b1;
    tick();
    chk(start_pulse, 1, "R10 high at reset release");
    tick();
    chk(start_pulse, 0, "R8 single pulse");

    // R1: each code picks its own source
    for (int c = 1; c < 8; c++) begin
      src_sel = 3'(c); trig_in = 7'd0;
      tick(); tick();
      trig_in = 7'd1 << (c % 7);
      tick();
      chk(start_pulse, 0, "R1 other source");
      trig_in[c-1] = 1'b1;
      tick();
      chk(start_pulse, 1, "R1 selected source");
      trig_in = 7'd0;
      tick();
    end

    // R3: switch low source -> high source
    src_sel = 3'd1; trig_in = 7'b0000010;
    tick(); tick();
    chk(start_pulse, 0, "R3 before switch");
    src_sel = 3'd2;
    tick();
    chk(start_pulse, 1, "R3 switch edge");
    tick();
    chk(start_pulse, 0, "R8 after switch");

    // R4 / R5
    src_sel = 3'd1; trig_in = 7'd0; conv_done = 1'b1;
    tick(); tick();
    src_sel = 3'd0;
    tick();
    chk(start_pulse, 0, "R4 switch to free run");
    tick();
    chk(start_pulse, 0, "R4 hold free run");
    conv_done = 1'b0;
    tick();
    conv_done = 1'b1;
    tick();
    chk(start_pulse, 1, "R5 complete edge");

    // R6
    diff_ch = 1'b1; conv_done = 1'b0;
    tick();
    conv_done = 1'b1;
    tick();
    chk(start_pulse, 0, "R6 no start");
    chk(cfg_err, 1, "R6 error flag");
    diff_ch = 1'b0; conv_done = 1'b0;
    tick(); tick();
    chk(cfg_err, 0, "R6 error clears");

    // R7
    src_sel = 3'd1; trig_in = 7'd0;
    tick(); tick();
    conv_busy = 1'b1; trig_in[0] = 1'b1;
    tick();
    chk(start_pulse, 0, "R7 busy edge");
    conv_busy = 1'b0;
    tick();
    chk(start_pulse, 0, "R7 not queued");

    // R2 enables
    conv_en = 1'b0; trig_in = 7'd0;
    tick();
    trig_in[0] = 1'b1;
    tick();
    chk(start_pulse, 0, "R2 conv_en low");
    conv_en = 1'b1; auto_en = 1'b0; trig_in = 7'd0;
    tick();
    trig_in[0] = 1'b1;
    tick();
    chk(start_pulse, 0, "R2 auto_en low");
    auto_en = 1'b1;

    // R9 mask load
    msk_we = 1'b1; msk_wdata = 16'hA5C3;
    tick();
    msk_we = 1'b0; pin_raw = 16'hFFFF;
    #1;
    chk(pin_rd, 16'h5A3C, "R9 masked read");

    // Random phase against the bench model
    for (int n = 0; n < 4000; n++) begin
      tick();
      chk(start_pulse, m_start, "R2 random start");
      chk(cfg_err, m_err, "R6 random err");
      chk(pin_rd, pin_raw & ~m_mask, "R9 random mask");
      if ($urandom_range(9) == 0) src_sel = 3'($urandom_range(7));
      for (int b = 0; b < 7; b++) if ($urandom_range(3) == 0) trig_in[b] = ~trig_in[b];
      if ($urandom_range(2) == 0) conv_done = ~conv_done;
      conv_busy = ($urandom_range(4) == 0);
      conv_en   = ($urandom_range(9) != 0);
      auto_en   = ($urandom_range(9) != 0);
      diff_ch   = ($urandom_range(9) == 0);
      msk_we    = ($urandom_range(19) == 0);
      msk_wdata = 16'($urandom);
      pin_raw   = 16'($urandom);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule